// File: doc/BRIEF.md
# Delayed Read Master-Abort Handler

This block follows one inbound delayed read per port. A read request arrives from a PCI-style target port and is carried to an internal bus master port. The first attempt of a request is always answered with a retry. The block latches the address, command and byte enables of that request, then drives the read on the internal bus until the bus either completes it or master-aborts it. The outcome is then held as a delayed completion. It is handed over only when the initiator repeats exactly the same request, and only then does the entry return to idle.

A master abort on the internal bus needs special handling. The block sets a sticky status bit, and that bit drives an interrupt line that cannot be masked. When the initiator retries, the block replies with a master-abort termination and returns no data. The queue entry stays in place until that reply has been given.

The block also covers the reverse case. When the internal bus reads through this block and the PCI side aborts, the block releases the internal bus and does not claim the cycle. It records no error for this case. The primary port and the secondary port each get their own copy of the whole handler, selected by the port index `p`.

Top module: `drm_handler`

## Requirements
- R1: When the entry is idle, a target request gets a RETRY response (code 1) one cycle later. From that same cycle, `ib_req` is high with the captured address, command and byte enables, and it stays high and stable until `ib_done` or `ib_abort`. If both arrive in the same cycle, the abort is taken.
- R2: Each port has a 2-bit response field at bits [2p+1:2p] of `tgt_rsp`, with these codes: 0 none, 1 retry, 2 data, 3 master abort. The response appears exactly one cycle after the request cycle. In every other cycle it reads 0.
- R3: After `ib_done`, a retry whose address, command and byte enables all equal the captured ones gets the DATA response (code 2). `tgt_rdata` then carries the word that was on `ib_rdata` in the done cycle, and the entry returns to idle.
- R4: Some requests get RETRY and leave the entry unchanged: any request while the internal read is outstanding, and, in either completed state, a request that differs in any one of address, command or byte enables.
- R5: After `ib_abort`, a matching retry gets the MASTER-ABORT response (code 3), and `tgt_rdata` is zero in that cycle.
- R6: The aborted entry stays in the abort-complete state until the master abort has been delivered. After delivery the entry is idle, and the next request starts a fresh capture.
- R7: Bit 7 of the port's 8-bit `csr_status` is set one cycle after an internal master abort and stays set until cleared. Bits 6..0 always read zero.
- R8: `irq` for a port is high whenever its status bit 7 is set, and no mask exists. A `csr_wr` with `csr_wdata` bit 7 equal to 1 clears the bit, and `irq` is low from the next cycle. A write with bit 7 equal to 0 changes nothing. If an abort and a clear arrive in the same cycle, the abort wins.
- R9: The two ports are independent. Traffic, aborts and clears on one port never change the other port's response, status or interrupt.
- R10: A `slv_req` is answered one cycle later. With `slv_pci_abort` low, `slv_claim` is 1 and `slv_release` is 0. With `slv_pci_abort` high, `slv_claim` is 0 and `slv_release` is 1. The two outputs are never high together.
- R11: A reverse-direction abort leaves the status register and `irq` unchanged.
- R12: After reset, all responses are 0, `ib_req`, `irq`, `slv_claim` and `slv_release` are 0, and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | NPORT | Target-side read request strobe per port |
| tgt_addr | input | NPORT*32 | Request address per port |
| tgt_cmd | input | NPORT*4 | Request command per port |
| tgt_be | input | NPORT*4 | Request byte enables per port |
| tgt_rsp | output | NPORT*2 | Response code per port |
| tgt_rdata | output | NPORT*DATA_W | Read data returned with DATA response |
| ib_req | output | NPORT | Internal bus read request per port |
| ib_addr | output | NPORT*32 | Captured address driven on internal bus |
| ib_cmd | output | NPORT*4 | Captured command driven on internal bus |
| ib_be | output | NPORT*4 | Captured byte enables driven on internal bus |
| ib_done | input | NPORT | Internal read completed with data |
| ib_abort | input | NPORT | Internal read master-aborted |
| ib_rdata | input | NPORT*DATA_W | Internal read data, valid with ib_done |
| csr_wr | input | NPORT | Status register write strobe |
| csr_wdata | input | NPORT*8 | Write-one-to-clear data |
| csr_status | output | NPORT*8 | Status register per port |
| irq | output | NPORT | Unmaskable interrupt per port |
| slv_req | input | NPORT | Reverse-direction delayed read outcome strobe |
| slv_pci_abort | input | NPORT | PCI side aborted the reverse read |
| slv_claim | output | NPORT | Claim the internal bus cycle |
| slv_release | output | NPORT | Release the internal bus without claiming |

## Verification
All target responses, `slv_claim` and `slv_release` change at the first clock edge after the cycle that carries their stimulus. The status bit and `irq` follow `ib_abort` or a clearing write by exactly one edge. `ib_req` and its fields change at the same edge as the RETRY that captures the request. The bench drives every input just after a rising edge, lets exactly one edge pass, and then compares each output against values it computes from the request fields and the port index. A check scheduled for a given cycle therefore sees exactly the result that cycle is due to produce, and never an earlier or later one.

// File: rtl/drm_pkg.sv
package drm_pkg;
    localparam int ADDR_W    = 32;
    localparam int CMD_W     = 4;
    localparam int BE_W      = 4;
    localparam int STAT_W    = 8;
    localparam int ABORT_BIT = 7;
    localparam int RSP_W     = 2;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PENDING    = 2'd1,
        ST_CMPL_DATA  = 2'd2,
        ST_CMPL_ABORT = 2'd3
    } dr_state_e;

    typedef enum logic [RSP_W-1:0] {
        RSP_NONE   = 2'd0,
        RSP_RETRY  = 2'd1,
        RSP_DATA   = 2'd2,
        RSP_MABORT = 2'd3
    } tgt_rsp_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [BE_W-1:0]   be;
    } rd_req_t;

    function automatic logic req_match(rd_req_t a, rd_req_t b);
        return (a.addr == b.addr) && (a.cmd == b.cmd) && (a.be == b.be);
    endfunction
endpackage

// File: rtl/drm_entry.sv
module drm_entry
    import drm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              t_vld,
    input  rd_req_t           t_req,
    output tgt_rsp_e          t_rsp,
    output logic [DATA_W-1:0] t_rdata,
    output logic              im_req,
    output rd_req_t           im_info,
    input  logic              im_done,
    input  logic              im_abort,
    input  logic [DATA_W-1:0] im_rdata,
    output logic              abort_evt
);
    dr_state_e         state_q;
    rd_req_t           cap_q;
    logic [DATA_W-1:0] hold_q;
    logic              hit;

    assign hit       = req_match(t_req, cap_q);
    assign im_req    = (state_q == ST_PENDING);
    assign im_info   = cap_q;
    assign abort_evt = (state_q == ST_PENDING) && im_abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cap_q   <= '0;
            hold_q  <= '0;
            t_rsp   <= RSP_NONE;
            t_rdata <= '0;
        end else begin
            t_rsp   <= RSP_NONE;
            t_rdata <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (t_vld) begin
                        cap_q   <= t_req;
                        t_rsp   <= RSP_RETRY;
                        state_q <= ST_PENDING;
                    end
                end
                ST_PENDING: begin
                    if (t_vld) t_rsp <= RSP_RETRY;
                    if (im_abort) begin
                        state_q <= ST_CMPL_ABORT;
                    end else if (im_done) begin
                        hold_q  <= im_rdata;
                        state_q <= ST_CMPL_DATA;
                    end
                end
                ST_CMPL_DATA: begin
                    if (t_vld) begin
                        if (hit) begin
                            t_rsp   <= RSP_DATA;
                            t_rdata <= hold_q;
                            state_q <= ST_IDLE;
                        end else begin
                            t_rsp <= RSP_RETRY;
                        end
                    end
                end
                default: begin
                    if (t_vld) begin
                        if (hit) begin
                            t_rsp   <= RSP_MABORT;
                            state_q <= ST_IDLE;
                        end else begin
                            t_rsp <= RSP_RETRY;
                        end
                    end
                end
            endcase
        end
    end

    a_r1_ib_hold: assert property (@(posedge clk) disable iff (rst)
        (im_req && !im_done && !im_abort) |=> (im_req && $stable(im_info)))
        else $error("R1: internal request dropped or changed before answer");

    a_r4_busy_mismatch_retry: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && t_vld && !hit) |=> (t_rsp == RSP_RETRY))
        else $error("R4: mismatching request not retried");

    a_r5_abort_no_data: assert property (@(posedge clk) disable iff (rst)
        (t_rsp == RSP_MABORT) |-> (t_rdata == '0))
        else $error("R5: data returned with master abort");

    a_r6_hold_until_delivered: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CMPL_ABORT && !t_vld) |=> (state_q == ST_CMPL_ABORT))
        else $error("R6: aborted entry flushed before delivery");
endmodule

// File: rtl/drm_status.sv
module drm_status
    import drm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_evt,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic abort_q;

    always_ff @(posedge clk) begin
        if (rst)                                abort_q <= 1'b0;
        else if (set_evt)                       abort_q <= 1'b1;
        else if (clr_wr && clr_data[ABORT_BIT]) abort_q <= 1'b0;
    end

    always_comb begin
        status            = '0;
        status[ABORT_BIT] = abort_q;
    end

    assign irq = abort_q;

    a_r7_abort_sets_bit: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> status[ABORT_BIT])
        else $error("R7: abort did not set status bit");

    a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_data[ABORT_BIT] && !set_evt) |=> !irq)
        else $error("R8: irq still high after clear");
endmodule

// File: rtl/drm_slave_fwd.sv
module drm_slave_fwd (
    input  logic clk,
    input  logic rst,
    input  logic slv_req,
    input  logic pci_abort,
    output logic claim,
    output logic release_bus
);
    always_ff @(posedge clk) begin
        if (rst) begin
            claim       <= 1'b0;
            release_bus <= 1'b0;
        end else begin
            claim       <= slv_req && !pci_abort;
            release_bus <= slv_req && pci_abort;
        end
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({claim, release_bus}))
        else $error("R10: claim and release both high");

    a_r10_answered: assert property (@(posedge clk) disable iff (rst)
        slv_req |=> (claim || release_bus))
        else $error("R10: reverse request not answered");
endmodule

// File: rtl/drm_handler.sv
module drm_handler
    import drm_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT-1:0]         tgt_valid,
    input  logic [NPORT*ADDR_W-1:0]  tgt_addr,
    input  logic [NPORT*CMD_W-1:0]   tgt_cmd,
    input  logic [NPORT*BE_W-1:0]    tgt_be,
    output logic [NPORT*RSP_W-1:0]   tgt_rsp,
    output logic [NPORT*DATA_W-1:0]  tgt_rdata,
    output logic [NPORT-1:0]         ib_req,
    output logic [NPORT*ADDR_W-1:0]  ib_addr,
    output logic [NPORT*CMD_W-1:0]   ib_cmd,
    output logic [NPORT*BE_W-1:0]    ib_be,
    input  logic [NPORT-1:0]         ib_done,
    input  logic [NPORT-1:0]         ib_abort,
    input  logic [NPORT*DATA_W-1:0]  ib_rdata,
    input  logic [NPORT-1:0]         csr_wr,
    input  logic [NPORT*STAT_W-1:0]  csr_wdata,
    output logic [NPORT*STAT_W-1:0]  csr_status,
    output logic [NPORT-1:0]         irq,
    input  logic [NPORT-1:0]         slv_req,
    input  logic [NPORT-1:0]         slv_pci_abort,
    output logic [NPORT-1:0]         slv_claim,
    output logic [NPORT-1:0]         slv_release
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rd_req_t  t_req;
        rd_req_t  im_info;
        tgt_rsp_e rsp;
        logic     abort_evt;

        assign t_req.addr = tgt_addr[p*ADDR_W +: ADDR_W];
        assign t_req.cmd  = tgt_cmd[p*CMD_W +: CMD_W];
        assign t_req.be   = tgt_be[p*BE_W +: BE_W];

        drm_entry #(.DATA_W(DATA_W)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .t_vld    (tgt_valid[p]),
            .t_req    (t_req),
            .t_rsp    (rsp),
            .t_rdata  (tgt_rdata[p*DATA_W +: DATA_W]),
            .im_req   (ib_req[p]),
            .im_info  (im_info),
            .im_done  (ib_done[p]),
            .im_abort (ib_abort[p]),
            .im_rdata (ib_rdata[p*DATA_W +: DATA_W]),
            .abort_evt(abort_evt)
        );

        assign tgt_rsp[p*RSP_W +: RSP_W] = rsp;
        assign ib_addr[p*ADDR_W +: ADDR_W] = im_info.addr;
        assign ib_cmd[p*CMD_W +: CMD_W]    = im_info.cmd;
        assign ib_be[p*BE_W +: BE_W]       = im_info.be;

        drm_status u_status (
            .clk     (clk),
            .rst     (rst),
            .set_evt (abort_evt),
            .clr_wr  (csr_wr[p]),
            .clr_data(csr_wdata[p*STAT_W +: STAT_W]),
            .status  (csr_status[p*STAT_W +: STAT_W]),
            .irq     (irq[p])
        );

        drm_slave_fwd u_fwd (
            .clk        (clk),
            .rst        (rst),
            .slv_req    (slv_req[p]),
            .pci_abort  (slv_pci_abort[p]),
            .claim      (slv_claim[p]),
            .release_bus(slv_release[p])
        );
    end
endmodule

// File: tb/tb_drm_handler.sv
module tb_drm_handler;
    localparam int NP = 2;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst;
    logic [NP-1:0]    tgt_valid;
    logic [NP*32-1:0] tgt_addr;
    logic [NP*4-1:0]  tgt_cmd, tgt_be;
    logic [NP*2-1:0]  tgt_rsp;
    logic [NP*DW-1:0] tgt_rdata;
    logic [NP-1:0]    ib_req;
    logic [NP*32-1:0] ib_addr;
    logic [NP*4-1:0]  ib_cmd, ib_be;
    logic [NP-1:0]    ib_done, ib_abort;
    logic [NP*DW-1:0] ib_rdata;
    logic [NP-1:0]    csr_wr;
    logic [NP*8-1:0]  csr_wdata, csr_status;
    logic [NP-1:0]    irq, slv_req, slv_pci_abort, slv_claim, slv_release;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    drm_handler #(.NPORT(NP), .DATA_W(DW)) dut (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        tgt_valid = '0; ib_done = '0; ib_abort = '0;
        csr_wr = '0; slv_req = '0; slv_pci_abort = '0;
    endtask

    task automatic req(int p, logic [31:0] a, logic [3:0] c, logic [3:0] b);
        tgt_valid[p] = 1'b1;
        tgt_addr[p*32 +: 32] = a;
        tgt_cmd[p*4 +: 4] = c;
        tgt_be[p*4 +: 4] = b;
    endtask

    function automatic logic [1:0] rsp(int p);
        return tgt_rsp[p*2 +: 2];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, d;
        logic [3:0]  c, b;
        int q;
        rst = 1'b1;
        tgt_valid = '0; tgt_addr = '0; tgt_cmd = '0; tgt_be = '0;
        ib_done = '0; ib_abort = '0; ib_rdata = '0;
        csr_wr = '0; csr_wdata = '0; slv_req = '0; slv_pci_abort = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R12 reset state
        chk("R12 rsp", {30'd0, tgt_rsp}, 32'd0);
        chk("R12 ib_req", {30'd0, ib_req}, 32'd0);
        chk("R12 status", {16'd0, csr_status}, 32'd0);
        chk("R12 irq", {30'd0, irq}, 32'd0);
        chk("R12 slave", {28'd0, slv_claim, slv_release}, 32'd0);

        for (int p = 0; p < NP; p++) begin
            q = 1 - p;
            a = 32'h1000_0040 + 32'(p * 16);
            c = 4'h6;
            b = 4'hF;
            // R1 capture and first retry
            req(p, a, c, b); tick();
            chk("R1 first retry", rsp(p), 2'd1);
            chk("R1 ib_req", ib_req[p], 1);
            chk("R1 ib_addr", ib_addr[p*32 +: 32], a);
            chk("R1 ib_cmd/be", {ib_cmd[p*4 +: 4], ib_be[p*4 +: 4]}, {c, b});
            tick();
            chk("R2 idle response", rsp(p), 2'd0);
            chk("R1 ib_req held", ib_req[p], 1);
            // R4 request while pending
            req(p, a, c, b); tick();
            chk("R4 pending retry", rsp(p), 2'd1);
            // R7 abort
            ib_abort[p] = 1'b1; tick();
            chk("R7 status set", csr_status[p*8 +: 8], 32'h80);
            chk("R8 irq", irq[p], 1);
            chk("R1 ib_req dropped", ib_req[p], 0);
            chk("R9 other status", csr_status[q*8 +: 8], 32'h0);
            chk("R9 other irq", irq[q], 0);
            // R4 mismatch in each field
            for (int f = 0; f < 3; f++) begin
                req(p, (f == 0) ? a ^ 32'h4 : a, (f == 1) ? c ^ 4'h1 : c,
                    (f == 2) ? b ^ 4'h8 : b);
                tick();
                chk("R4 abort mismatch retry", rsp(p), 2'd1);
            end
            // R8 write with bit 7 clear: no effect
            csr_wr[p] = 1'b1; csr_wdata[p*8 +: 8] = 8'h7F; tick();
            chk("R8 zero write ignored", csr_status[p*8 +: 8], 32'h80);
            // R5 deliver abort
            req(p, a, c, b); tick();
            chk("R5 mabort", rsp(p), 2'd3);
            chk("R5 no data", tgt_rdata[p*32 +: 32], 32'd0);
            chk("R7 sticky", csr_status[p*8 +: 8], 32'h80);
            chk("R9 other rsp", rsp(q), 2'd0);
            // R6 entry retired; fresh capture
            req(p, a, c, b); tick();
            chk("R6 fresh retry", rsp(p), 2'd1);
            chk("R6 fresh ib_req", ib_req[p], 1);
            // R3 data path sweep over byte enables
            for (int k = 0; k < 4; k++) begin
                if (k > 0) begin
                    req(p, a + 32'(k * 4), c, 4'(k)); tick();
                    chk("R1 retry sweep", rsp(p), 2'd1);
                end
                d = (a ^ 32'h5A5A_0000) + 32'(k * 3 + p);
                ib_done[p] = 1'b1; ib_rdata[p*32 +: 32] = d; tick();
                chk("R3 ib_req dropped", ib_req[p], 0);
                req(p, a + 32'(k * 4) + 32'h100, c, (k > 0) ? 4'(k) : b); tick();
                chk("R4 data mismatch retry", rsp(p), 2'd1);
                req(p, a + 32'(k * 4), c, (k > 0) ? 4'(k) : b); tick();
                chk("R3 data rsp", rsp(p), 2'd2);
                chk("R3 data value", tgt_rdata[p*32 +: 32], d);
            end
            chk("R7 still set", csr_status[p*8 +: 8], 32'h80);
            // R8 clear
            csr_wr[p] = 1'b1; csr_wdata[p*8 +: 8] = 8'h80; tick();
            chk("R8 cleared", csr_status[p*8 +: 8], 32'h0);
            chk("R8 irq low", irq[p], 0);
            // R8 set wins over clear; R1 abort wins over done
            req(p, a, c, b); tick();
            ib_abort[p] = 1'b1; ib_done[p] = 1'b1; ib_rdata[p*32 +: 32] = 32'hDEAD_BEEF;
            csr_wr[p] = 1'b1; csr_wdata[p*8 +: 8] = 8'hFF; tick();
            chk("R8 set beats clear", csr_status[p*8 +: 8], 32'h80);
            req(p, a, c, b); tick();
            chk("R1 abort beats done", rsp(p), 2'd3);
            chk("R5 no data after tie", tgt_rdata[p*32 +: 32], 32'd0);
            csr_wr[p] = 1'b1; csr_wdata[p*8 +: 8] = 8'h80; tick();
            chk("R8 cleared again", irq[p], 0);
            // R10 / R11 reverse direction
            slv_req[p] = 1'b1; slv_pci_abort[p] = 1'b1; tick();
            chk("R10 release on abort", {slv_claim[p], slv_release[p]}, 32'b01);
            chk("R11 no status", csr_status[p*8 +: 8], 32'h0);
            chk("R11 no irq", irq[p], 0);
            slv_req[p] = 1'b1; tick();
            chk("R10 claim on success", {slv_claim[p], slv_release[p]}, 32'b10);
            tick();
            chk("R10 idle", {slv_claim[p], slv_release[p]}, 32'b00);
        end
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule